// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block sits at the issue stage of a statically scheduled, two-wide pipeline for a 32-bit load/store instruction set. Each cycle the fetch unit presents one 64-bit packet and its fetch address. The packet holds two instruction words. The lower word (bits 31:0) is the compute slot, which holds an ALU operation, a conditional branch or a nop. The upper word (bits 63:32) is the memory slot, which holds a load, a store or a nop.

The checker rejects packets that break the slot rules or are fetched from a misaligned address. It finds two kinds of register dependency:
- a memory slot that reads the register the compute slot of the same packet writes;
- a packet that reads the register loaded by the packet issued in the cycle before it.

For each packet it answers in the same cycle. It can issue both slots, issue the compute slot alone and hold the memory slot, or insert a bubble. While `stall` is high, the front end must present the same packet again in the next cycle.

Decoding uses the 6-bit opcode in bits 31:26 of each word. The source fields are rs in bits 25:21 and rt in bits 20:16. A register-register operation writes rd in bits 15:11.

Top module: `pair_issue_guard`

## Requirements
- R1: After reset, with `pktValid` low, all outputs are 0. No load is remembered, so the first legal packet issues both slots whatever registers it reads.
- R2: When the fetch address has any of its low three bits set, `illegal` is 1 and `issueAlu`, `issueMem` and `stall` are all 0 in that cycle.
- R3: `illegal` is 1 and nothing issues in any of these cases:
  - the compute slot is not one of: the all-zero nop, opcode 0x00 (register-register), opcodes 0x08 to 0x0F (immediate ALU), 0x04 or 0x05 (branches);
  - the memory slot is not one of: the nop, opcode 0x23 (load), 0x2B (store).
- R4: A legal, aligned packet with no dependency issues both slots in the same cycle, with `stall` 0.
- R5: When the compute slot writes a nonzero register that the memory slot reads, the packet is split:
  - R5 (first cycle, base rs or store data rt): `issueAlu`=1, `issueMem`=0, `stall`=1. The destination is rd for opcode 0x00 and rt for immediate ALU opcodes.
  - R5 (second cycle): when the same packet is presented again, `issueAlu`=0, `issueMem`=1 and `stall`=0.
- R6: When the previous cycle issued a load to a nonzero register and either slot of the current packet reads that register, the cycle is a bubble: no issue, `stall`=1. On the next cycle the same packet issues normally.
- R7: Register 0 never creates a dependency, neither inside a packet nor after a load.
- R8: A load destination is remembered for exactly one cycle. If an idle cycle or an unrelated packet comes between the load and a reader, the reader does not stall.
- R9: While `pktValid` is low, all four outputs are 0.
- R10: A load issued in the second cycle of a split packet creates a load-use dependency for the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | A packet is presented this cycle |
| pktWord | input | 64 | Packet: compute slot in 31:0, memory slot in 63:32 |
| pktAddr | input | 32 | Fetch address of the packet |
| issueAlu | output | 1 | Issue the compute slot this cycle |
| issueMem | output | 1 | Issue the memory slot this cycle |
| stall | output | 1 | Present the same packet again next cycle |
| illegal | output | 1 | Packet breaks slot typing or alignment; nothing issues |

## Verification
The bench targets the following corner cases:
- **Split packet.** A design that forgot the pending half would issue the compute slot twice or never issue the memory slot. The store-data case (a dependency through rt rather than the base register) is also covered.
- **Load after a split.** A load issued in the second half of a split must still stall a dependent next packet. If the load record came only from full issues, this dependency would be missed.
- **Register 0.** Loads to register 0 and compute writes of register 0 must not stall. A design comparing raw fields would insert spurious bubbles.
- **One-cycle window of the load record.** The record must expire after one cycle. A record that lingers would stall a packet two cycles later.
- **Slot typing and alignment.** Swapped slots, jump opcodes and misaligned fetch addresses must each raise the error. A design that checked only one of these would issue the bad packet.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  localparam int INSN_W = 32;
  localparam int REG_AW = 5;
  localparam int OPC_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG    = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE    = 6'h05;
  localparam logic [OPC_W-1:0] OPC_IMM_LO = 6'h08;
  localparam logic [OPC_W-1:0] OPC_IMM_HI = 6'h0F;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;

  typedef enum logic [2:0] {
    CLS_NOP, CLS_ALU, CLS_BRANCH, CLS_LOAD, CLS_STORE, CLS_BAD
  } slotClass_e;

  // Register fields are zero when unused, so register 0 means "none".
  typedef struct packed {
    slotClass_e        cls;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] srcA;
    logic [REG_AW-1:0] srcB;
  } slotInfo_t;

  typedef struct packed {
    logic recordLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/pair_issue_slot_decode.sv
module pair_issue_slot_decode
  import pair_issue_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output slotInfo_t         info
);
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_AW;
  localparam int RT_LSB  = RS_LSB - REG_AW;
  localparam int RD_LSB  = RT_LSB - REG_AW;

  logic [OPC_W-1:0]  opc;
  logic [REG_AW-1:0] rs, rt, rd;

  assign opc = insn[OPC_LSB +: OPC_W];
  assign rs  = insn[RS_LSB +: REG_AW];
  assign rt  = insn[RT_LSB +: REG_AW];
  assign rd  = insn[RD_LSB +: REG_AW];

  always_comb begin
    info = '{cls: CLS_BAD, dst: '0, srcA: '0, srcB: '0};
    if (insn == '0) begin
      info.cls = CLS_NOP;
    end else if (opc == OPC_REG) begin
      info = '{cls: CLS_ALU, dst: rd, srcA: rs, srcB: rt};
    end else if (opc >= OPC_IMM_LO && opc <= OPC_IMM_HI) begin
      info = '{cls: CLS_ALU, dst: rt, srcA: rs, srcB: '0};
    end else if (opc == OPC_BEQ || opc == OPC_BNE) begin
      info = '{cls: CLS_BRANCH, dst: '0, srcA: rs, srcB: rt};
    end else if (opc == OPC_LOAD) begin
      info = '{cls: CLS_LOAD, dst: rt, srcA: rs, srcB: '0};
    end else if (opc == OPC_STORE) begin
      info = '{cls: CLS_STORE, dst: '0, srcA: rs, srcB: rt};
    end
  end
endmodule

// File: rtl/pair_issue_datapath.sv
module pair_issue_datapath
  import pair_issue_pkg::*;
#(
  parameter int SLOTS      = 2,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3,
  localparam int PKT_W     = SLOTS * INSN_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PKT_W-1:0]  pktWord,
  input  logic [ADDR_W-1:0] pktAddr,
  input  ctrlStrobe_t       strobe,
  output logic              badPkt,
  output logic              loadUse,
  output logic              intraDep
);
  slotInfo_t slotInfo [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    pair_issue_slot_decode u_dec (
      .insn (pktWord[s*INSN_W +: INSN_W]),
      .info (slotInfo[s])
    );
  end

  slotInfo_t aluSlot, memSlot;
  assign aluSlot = slotInfo[0];
  assign memSlot = slotInfo[1];

  logic aluTyped, memTyped, aligned;
  assign aluTyped = aluSlot.cls inside {CLS_NOP, CLS_ALU, CLS_BRANCH};
  assign memTyped = memSlot.cls inside {CLS_NOP, CLS_LOAD, CLS_STORE};
  assign aligned  = (pktAddr[ALIGN_BITS-1:0] == '0);
  assign badPkt   = !(aluTyped && memTyped && aligned);

  assign intraDep = (aluSlot.dst != '0) &&
                    ((aluSlot.dst == memSlot.srcA) || (aluSlot.dst == memSlot.srcB));

  logic              loadValid;
  logic [REG_AW-1:0] loadDst;

  assign loadUse = loadValid &&
                   ((loadDst == aluSlot.srcA) || (loadDst == aluSlot.srcB) ||
                    (loadDst == memSlot.srcA) || (loadDst == memSlot.srcB));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid <= 1'b0;
      loadDst   <= '0;
    end else begin
      loadValid <= strobe.recordLoad && (memSlot.cls == CLS_LOAD) && (memSlot.dst != '0);
      loadDst   <= memSlot.dst;
    end
  end
endmodule

// File: rtl/pair_issue_control.sv
module pair_issue_control
  import pair_issue_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  logic        badPkt,
  input  logic        loadUse,
  input  logic        intraDep,
  output logic        issueAlu,
  output logic        issueMem,
  output logic        stall,
  output logic        illegal,
  output ctrlStrobe_t strobe
);
  logic splitPending, splitNext;

  always_comb begin
    issueAlu  = 1'b0;
    issueMem  = 1'b0;
    stall     = 1'b0;
    illegal   = 1'b0;
    splitNext = splitPending;
    if (pktValid) begin
      if (badPkt) begin
        illegal   = 1'b1;
        splitNext = 1'b0;
      end else if (splitPending) begin
        issueMem  = 1'b1;
        splitNext = 1'b0;
      end else if (loadUse) begin
        stall = 1'b1;
      end else if (intraDep) begin
        issueAlu  = 1'b1;
        stall     = 1'b1;
        splitNext = 1'b1;
      end else begin
        issueAlu = 1'b1;
        issueMem = 1'b1;
      end
    end
    strobe.recordLoad = issueMem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) splitPending <= 1'b0;
    else       splitPending <= splitNext;
  end
endmodule

// File: rtl/pair_issue_guard.sv
module pair_issue_guard
  import pair_issue_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  logic [63:0] pktWord,
  input  logic [31:0] pktAddr,
  output logic        issueAlu,
  output logic        issueMem,
  output logic        stall,
  output logic        illegal
);
  ctrlStrobe_t strobe;
  logic badPkt, loadUse, intraDep;

  pair_issue_datapath #(
    .SLOTS(2), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pktWord(pktWord), .pktAddr(pktAddr[ADDR_W-1:0]),
    .strobe(strobe), .badPkt(badPkt), .loadUse(loadUse), .intraDep(intraDep)
  );

  pair_issue_control u_ctl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .badPkt(badPkt),
    .loadUse(loadUse), .intraDep(intraDep), .issueAlu(issueAlu),
    .issueMem(issueMem), .stall(stall), .illegal(illegal), .strobe(strobe)
  );
endmodule

// File: rtl/pair_issue_guard_chk.sv
module pair_issue_guard_chk (
  input logic clk,
  input logic rstN,
  input logic pktValid,
  input logic issueAlu,
  input logic issueMem,
  input logic stall,
  input logic illegal
);
  AST_ILLEGAL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!issueAlu && !issueMem && !stall)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> (!issueAlu && !issueMem && !stall && !illegal)); // R9

  AST_SPLIT_NO_REPEAT: assert property (@(posedge clk) disable iff (!rstN)
    (issueAlu && !issueMem) |=> !issueAlu); // R5

  AST_MEM_HALF_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (issueMem && !issueAlu) |-> !stall); // R5

  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !issueAlu) |=> !(stall && !issueAlu)); // R6
endmodule

bind pair_issue_guard pair_issue_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .pktValid(pktValid), .issueAlu(issueAlu),
  .issueMem(issueMem), .stall(stall), .illegal(illegal)
);

// File: tb/pair_issue_guard_bench.sv
module pair_issue_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktValid = 1'b0;
  logic [63:0] pktWord = '0;
  logic [31:0] pktAddr = '0;
  logic        issueAlu, issueMem, stall, illegal;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  pair_issue_guard u_pair_issue_guard (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktWord(pktWord),
    .pktAddr(pktAddr), .issueAlu(issueAlu), .issueMem(issueMem),
    .stall(stall), .illegal(illegal)
  );

  function automatic logic [31:0] opReg(input logic [4:0] rd, rs, rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] opImm(input logic [4:0] rt, rs);
    return {6'h08, rs, rt, 16'd1};
  endfunction
  function automatic logic [31:0] opLoad(input logic [4:0] rt, rs);
    return {6'h23, rs, rt, 16'd0};
  endfunction
  function automatic logic [31:0] opStore(input logic [4:0] rt, rs);
    return {6'h2B, rs, rt, 16'd0};
  endfunction
  function automatic logic [31:0] opBeq(input logic [4:0] rs, rt);
    return {6'h04, rs, rt, 16'd4};
  endfunction
  localparam logic [31:0] NOP = 32'h0;
  localparam logic [31:0] JMP = {6'h02, 26'd16};

  // Drive after the falling edge; outputs are combinational, so sample 2 ns later.
  task automatic present(input logic v, input logic [31:0] aluW, memW, input logic [31:0] addr);
    @(negedge clk);
    pktValid = v;
    pktWord  = {memW, aluW};
    pktAddr  = addr;
    #2;
  endtask

  task automatic expect4(input string tag, input logic a, m, s, e);
    checks++;
    if ({issueAlu, issueMem, stall, illegal} !== {a, m, s, e}) begin
      errors++;
      $display("FAIL %s: got alu/mem/stall/illegal=%b%b%b%b expected %b%b%b%b",
               tag, issueAlu, issueMem, stall, illegal, a, m, s, e);
    end
  endtask

  task automatic t_reset();
    present(1'b0, NOP, NOP, 32'h0);
    expect4("R1 idle after reset", 0, 0, 0, 0);
    present(1'b1, opReg(5'd3, 5'd1, 5'd2), opLoad(5'd4, 5'd6), 32'h100);
    expect4("R1 first packet issues both", 1, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
  endtask

  task automatic t_independent();
    present(1'b1, opReg(5'd3, 5'd1, 5'd2), opLoad(5'd4, 5'd6), 32'h200);
    expect4("R4 add+load", 1, 1, 0, 0);
    present(1'b1, NOP, NOP, 32'h208);
    expect4("R4 nop pair after load", 1, 1, 0, 0);
    present(1'b1, opImm(5'd7, 5'd8), opStore(5'd9, 5'd10), 32'h210);
    expect4("R4 imm+store", 1, 1, 0, 0);
    present(1'b1, opBeq(5'd1, 5'd2), opLoad(5'd11, 5'd12), 32'h218);
    expect4("R4 branch+load", 1, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
  endtask

  task automatic t_misaligned();
    present(1'b1, opReg(5'd3, 5'd1, 5'd2), NOP, 32'h204);
    expect4("R2 addr low bits 100", 0, 0, 0, 1);
    present(1'b1, NOP, NOP, 32'h201);
    expect4("R2 addr low bits 001", 0, 0, 0, 1);
  endtask

  task automatic t_badslot();
    present(1'b1, opLoad(5'd3, 5'd1), opReg(5'd4, 5'd1, 5'd2), 32'h300);
    expect4("R3 swapped slots", 0, 0, 0, 1);
    present(1'b1, JMP, NOP, 32'h308);
    expect4("R3 jump opcode in compute slot", 0, 0, 0, 1);
    present(1'b1, NOP, opImm(5'd5, 5'd6), 32'h310);
    expect4("R3 ALU op in memory slot", 0, 0, 0, 1);
  endtask

  task automatic t_intra();
    present(1'b1, opReg(5'd3, 5'd1, 5'd2), opLoad(5'd4, 5'd3), 32'h400);
    expect4("R5 split first half", 1, 0, 1, 0);
    present(1'b1, opReg(5'd3, 5'd1, 5'd2), opLoad(5'd4, 5'd3), 32'h400);
    expect4("R5 split second half", 0, 1, 0, 0);
    present(1'b1, opReg(5'd5, 5'd4, 5'd1), NOP, 32'h408);
    expect4("R10 load from split half stalls reader", 0, 0, 1, 0);
    present(1'b1, opReg(5'd5, 5'd4, 5'd1), NOP, 32'h408);
    expect4("R6 reader issues after bubble", 1, 1, 0, 0);
    present(1'b1, opImm(5'd5, 5'd0), opStore(5'd5, 5'd6), 32'h410);
    expect4("R5 store data split first", 1, 0, 1, 0);
    present(1'b1, opImm(5'd5, 5'd0), opStore(5'd5, 5'd6), 32'h410);
    expect4("R5 store data split second", 0, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
  endtask

  task automatic t_loaduse();
    present(1'b1, NOP, opLoad(5'd8, 5'd1), 32'h500);
    expect4("R6 load issues", 1, 1, 0, 0);
    present(1'b1, opReg(5'd9, 5'd8, 5'd2), NOP, 32'h508);
    expect4("R6 compute reader bubble", 0, 0, 1, 0);
    present(1'b1, opReg(5'd9, 5'd8, 5'd2), NOP, 32'h508);
    expect4("R6 compute reader after bubble", 1, 1, 0, 0);
    present(1'b1, NOP, opLoad(5'd8, 5'd1), 32'h510);
    expect4("R6 second load issues", 1, 1, 0, 0);
    present(1'b1, NOP, opStore(5'd2, 5'd8), 32'h518);
    expect4("R6 memory slot base reader bubble", 0, 0, 1, 0);
    present(1'b1, NOP, opStore(5'd2, 5'd8), 32'h518);
    expect4("R6 memory reader after bubble", 1, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
  endtask

  task automatic t_zero();
    present(1'b1, NOP, opLoad(5'd0, 5'd1), 32'h600);
    expect4("R7 load to r0", 1, 1, 0, 0);
    present(1'b1, opReg(5'd3, 5'd0, 5'd0), NOP, 32'h608);
    expect4("R7 reader of r0 not stalled", 1, 1, 0, 0);
    present(1'b1, opReg(5'd0, 5'd1, 5'd2), opStore(5'd0, 5'd0), 32'h610);
    expect4("R7 compute write of r0 no split", 1, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
  endtask

  task automatic t_expire();
    present(1'b1, NOP, opLoad(5'd8, 5'd1), 32'h700);
    expect4("R8 load issues", 1, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
    present(1'b1, opReg(5'd9, 5'd8, 5'd2), NOP, 32'h708);
    expect4("R8 reader after idle cycle", 1, 1, 0, 0);
    present(1'b1, NOP, opLoad(5'd8, 5'd1), 32'h710);
    present(1'b1, opImm(5'd12, 5'd13), NOP, 32'h718);
    expect4("R8 unrelated packet", 1, 1, 0, 0);
    present(1'b1, NOP, opStore(5'd8, 5'd8), 32'h720);
    expect4("R8 reader two packets later", 1, 1, 0, 0);
    present(1'b0, NOP, NOP, 32'h0);
  endtask

  task automatic t_idle();
    present(1'b0, opLoad(5'd3, 5'd1), JMP, 32'h803);
    expect4("R9 garbage with valid low", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_independent();
    t_misaligned();
    t_badslot();
    t_intra();
    t_loaduse();
    t_zero();
    t_expire();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule